// File: doc/BRIEF.md
# Custom Opcode Handle Redirect Unit

This unit sits on the decode side of a core that offers eight generic custom instruction slots. The meaning of each slot is not fixed. Software binds a slot at run time by issuing an open-handle operation that carries a globally unique extension identifier. A close-handle operation returns the slot to a reserved "unbound" code that matches no extension.

When decode presents a slot instruction, the unit reads that slot's binding. It compares the binding against a small parameter list of supported extension identifiers, checking them in list order. The result is one of two outcomes:
- a one-hot select naming the functional unit that must execute the instruction, or
- an illegal-instruction trap, if the binding matches nothing.

A table write becomes visible in the following cycle. While a write is in progress, the unit raises a stall so the pipeline can hold dependent instructions.

Neither port carries a ready signal, and the unit never applies back-pressure. Every management operation and every issue is consumed in the cycle it is presented. The `stall` output is the only flow-control indication, and it is driven upstream for the pipeline to act on.

Top module: `cx_slot_router`

## Requirements
- R1: After reset every slot holds the unbound code (all ones), so an issue to any slot raises `trap` with `sel` all zeros.
- R2: An open operation (`mgmt_op`=1) writes `mgmt_id` into slot `mgmt_slot`. A later issue to that slot whose binding equals supported identifier k drives `sel` with only bit k set and `trap` low. Identifier k is entry k of `EXT_IDS`, default k=0: 0xC0DE0001, k=1: 0xC0DE0002.
- R3: A close operation (`mgmt_op`=0) sets the slot back to the unbound code, so a later issue to it traps.
- R4: Supported identifiers are compared in ascending index order, and the lowest matching index wins, so `sel` is never more than one-hot.
- R5: An issue whose binding matches no supported identifier raises `trap` and leaves `sel` all zeros.
- R6: When `issue_valid` is low, `sel` is zero and `trap` is low.
- R7: A table write takes effect in the cycle after it is presented. An issue to the same slot in the same cycle sees the previous binding.
- R8: `stall` is high in exactly the cycles where a management operation with a legal slot (0 to 7) is presented.
- R9: A management operation with slot number above 7 changes no entry and does not raise `stall`. It pulses `mgmt_err` high for the single following cycle.
- R10: A write to one slot leaves the bindings of all other slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_valid | input | 1 | Management operation present |
| mgmt_op | input | 1 | 1 = open handle, 0 = close handle |
| mgmt_slot | input | MSLOT_W (4) | Target slot; values above 7 are illegal |
| mgmt_id | input | ID_W (32) | Extension identifier for open |
| issue_valid | input | 1 | Slot instruction issued this cycle |
| issue_slot | input | 3 | Slot number of the issued instruction |
| sel | output | N_EXT (2) | One-hot functional unit select |
| trap | output | 1 | Illegal-instruction trap |
| stall | output | 1 | Table update in progress |
| mgmt_err | output | 1 | One-cycle pulse after an illegal slot number |

## Verification
The bench targets the same-cycle write and issue. A design that forwarded the new binding would dispatch one cycle early, where it should show the old binding with `stall` high.

An out-of-range slot of 9 is followed by an issue to slot 1. This catches a design that truncates the slot number and corrupts slot 1 instead of ignoring the operation.

Further cases cover a rebind from one extension to another, a close followed by an issue, an unknown identifier, and the highest slot. The bench also fires a reset after bindings exist, so a design that left stale entries behind would dispatch instead of trapping.

// File: rtl/cx_pkg.sv
`timescale 1ns/1ps
package cx_pkg;
  typedef enum logic {
    CX_CLOSE = 1'b0,
    CX_OPEN  = 1'b1
  } cx_op_e;
endpackage

// File: rtl/cx_bind_table.sv
`timescale 1ns/1ps
module cx_bind_table
  import cx_pkg::*;
#(
  parameter int          N_SLOT  = 8,
  parameter int          ID_W    = 32,
  parameter int          MSLOT_W = 4,
  parameter logic [ID_W-1:0] UNBOUND = '1,
  localparam int         SLOT_W  = $clog2(N_SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  cx_op_e            wr_op,
  input  logic [MSLOT_W-1:0] wr_slot,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [ID_W-1:0]   rd_id,
  output logic              upd_busy,
  output logic              bad_slot
);
  logic              legal;
  logic [ID_W-1:0]   entry [N_SLOT];
  logic [ID_W-1:0]   wr_val;
  logic              bad_q;

  assign legal    = (wr_slot < MSLOT_W'(N_SLOT));
  assign upd_busy = wr_en && legal;
  assign wr_val   = (wr_op == CX_OPEN) ? wr_id : UNBOUND;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry[s] <= UNBOUND;
      else if (upd_busy && (wr_slot == MSLOT_W'(s)))
        entry[s] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= wr_en && !legal;
  end

  assign rd_id    = entry[rd_slot];
  assign bad_slot = bad_q;
endmodule

// File: rtl/cx_id_match.sv
`timescale 1ns/1ps
module cx_id_match #(
  parameter int ID_W  = 32,
  parameter int N_EXT = 2,
  parameter logic [N_EXT-1:0][ID_W-1:0] EXT_IDS = {32'hC0DE_0002, 32'hC0DE_0001}
) (
  input  logic [ID_W-1:0]  id,
  output logic [N_EXT-1:0] hit_oh,
  output logic             miss
);
  logic [N_EXT-1:0] raw;

  for (genvar k = 0; k < N_EXT; k++) begin : g_cmp
    assign raw[k] = (id == EXT_IDS[k]);
  end

  always_comb begin
    hit_oh = '0;
    for (int k = N_EXT - 1; k >= 0; k--) begin
      if (raw[k]) begin
        hit_oh    = '0;
        hit_oh[k] = 1'b1;
      end
    end
  end

  assign miss = (raw == '0);
endmodule

// File: rtl/cx_slot_router.sv
`timescale 1ns/1ps
module cx_slot_router
  import cx_pkg::*;
#(
  parameter int N_SLOT  = 8,
  parameter int ID_W    = 32,
  parameter int N_EXT   = 2,
  parameter int MSLOT_W = 4,
  parameter logic [ID_W-1:0] UNBOUND = '1,
  parameter logic [N_EXT-1:0][ID_W-1:0] EXT_IDS = {32'hC0DE_0002, 32'hC0DE_0001},
  localparam int SLOT_W = $clog2(N_SLOT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mgmt_valid,
  input  logic               mgmt_op,
  input  logic [MSLOT_W-1:0] mgmt_slot,
  input  logic [ID_W-1:0]    mgmt_id,
  input  logic               issue_valid,
  input  logic [SLOT_W-1:0]  issue_slot,
  output logic [N_EXT-1:0]   sel,
  output logic               trap,
  output logic               stall,
  output logic               mgmt_err
);
  logic [ID_W-1:0]  bound_id;
  logic [N_EXT-1:0] hit_oh;
  logic             miss;
  cx_op_e           op_e;

  assign op_e = cx_op_e'(mgmt_op);

  cx_bind_table #(
    .N_SLOT(N_SLOT), .ID_W(ID_W), .MSLOT_W(MSLOT_W), .UNBOUND(UNBOUND)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(mgmt_valid), .wr_op(op_e), .wr_slot(mgmt_slot), .wr_id(mgmt_id),
    .rd_slot(issue_slot), .rd_id(bound_id),
    .upd_busy(stall), .bad_slot(mgmt_err)
  );

  cx_id_match #(
    .ID_W(ID_W), .N_EXT(N_EXT), .EXT_IDS(EXT_IDS)
  ) u_match (
    .id(bound_id), .hit_oh(hit_oh), .miss(miss)
  );

  assign sel  = issue_valid ? hit_oh : '0;
  assign trap = issue_valid && miss;
endmodule

// File: rtl/cx_slot_router_chk.sv
`timescale 1ns/1ps
module cx_slot_router_chk #(
  parameter int N_EXT   = 2,
  parameter int MSLOT_W = 4,
  parameter int SLOT_W  = 3,
  parameter int N_SLOT  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mgmt_valid,
  input logic               mgmt_op,
  input logic [MSLOT_W-1:0] mgmt_slot,
  input logic               issue_valid,
  input logic [SLOT_W-1:0]  issue_slot,
  input logic [N_EXT-1:0]   sel,
  input logic               trap,
  input logic               stall,
  input logic               mgmt_err
);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (sel == '0 && !trap));

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ((|sel) != trap));

  // R8
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall == (mgmt_valid && (mgmt_slot < MSLOT_W'(N_SLOT))));

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_valid && (mgmt_slot >= MSLOT_W'(N_SLOT))) |=> mgmt_err);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mgmt_valid && (mgmt_slot >= MSLOT_W'(N_SLOT))) |=> !mgmt_err);

  // R3
  close_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_valid && !mgmt_op && mgmt_slot < MSLOT_W'(N_SLOT))
      ##1 (issue_valid && MSLOT_W'(issue_slot) == $past(mgmt_slot)) |-> trap);
endmodule

bind cx_slot_router cx_slot_router_chk #(
  .N_EXT(N_EXT), .MSLOT_W(MSLOT_W), .SLOT_W(SLOT_W), .N_SLOT(N_SLOT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mgmt_valid(mgmt_valid), .mgmt_op(mgmt_op),
  .mgmt_slot(mgmt_slot), .issue_valid(issue_valid), .issue_slot(issue_slot),
  .sel(sel), .trap(trap), .stall(stall), .mgmt_err(mgmt_err)
);

// File: tb/tb_cx_slot_router.sv
`timescale 1ns/1ps
module tb_cx_slot_router;
  localparam logic [31:0] ID0 = 32'hC0DE_0001;
  localparam logic [31:0] ID1 = 32'hC0DE_0002;
  localparam logic [31:0] IDX = 32'h1234_5678;

  // vector: req[19:16] mv[15] op[14] mslot[13:10] idsel[9:8] iv[7] islot[6:4] esel[3:2] etrap[1] estall[0]
  function automatic logic [19:0] mkv(int req, bit mv, bit op, int ms, int ids,
                                      bit iv, int is, int es, bit et, bit est);
    return {4'(req), mv, op, 4'(ms), 2'(ids), iv, 3'(is), 2'(es), et, est};
  endfunction

  localparam int NV = 16;
  localparam logic [19:0] VEC [NV] = '{
    mkv(1, 0,0,0,0, 1,0, 0,1,0),  // R1 unbound slot 0 traps
    mkv(7, 1,1,0,0, 1,0, 0,1,1),  // R7 same-cycle issue sees old binding
    mkv(2, 0,0,0,0, 1,0, 1,0,0),  // R2 slot0 -> ext0
    mkv(8, 1,1,3,1, 0,0, 0,0,1),  // R8 stall on legal write, R6 idle
    mkv(2, 0,0,0,0, 1,3, 2,0,0),  // R2 slot3 -> ext1
    mkv(10,0,0,0,0, 1,0, 1,0,0),  // R10 slot0 untouched
    mkv(7, 1,1,5,2, 1,5, 0,1,1),  // R7 unknown id open, old value still unbound
    mkv(5, 0,0,0,0, 1,5, 0,1,0),  // R5 unknown id traps
    mkv(10,1,0,0,0, 1,3, 2,0,1),  // R10 close slot0, slot3 intact
    mkv(3, 0,0,0,0, 1,0, 0,1,0),  // R3 closed slot traps
    mkv(8, 1,1,7,1, 0,0, 0,0,1),  // R8 highest slot write
    mkv(2, 0,0,0,0, 1,7, 2,0,0),  // R2 slot7 -> ext1
    mkv(9, 1,1,9,0, 1,1, 0,1,0),  // R9 slot 9 ignored, no stall
    mkv(9, 0,0,0,0, 1,1, 0,1,0),  // R9 slot1 not aliased
    mkv(7, 1,1,3,0, 1,3, 2,0,1),  // R7 rebind slot3, old seen
    mkv(4, 0,0,0,0, 1,3, 1,0,0)   // R4 slot3 now ext0
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic mgmt_valid = 1'b0, mgmt_op = 1'b0;
  logic [3:0] mgmt_slot = '0;
  logic [31:0] mgmt_id = '0;
  logic issue_valid = 1'b0;
  logic [2:0] issue_slot = '0;
  logic [1:0] sel;
  logic trap, stall, mgmt_err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cx_slot_router dut (
    .clk(clk), .rst_n(rst_n), .mgmt_valid(mgmt_valid), .mgmt_op(mgmt_op),
    .mgmt_slot(mgmt_slot), .mgmt_id(mgmt_id), .issue_valid(issue_valid),
    .issue_slot(issue_slot), .sel(sel), .trap(trap), .stall(stall),
    .mgmt_err(mgmt_err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    mgmt_valid = 0; issue_valid = 0; mgmt_op = 0; mgmt_slot = 0; mgmt_id = 0; issue_slot = 0;
  endtask

  function automatic logic [31:0] idv(int s);
    case (s)
      0: return ID0;
      1: return ID1;
      default: return IDX;
    endcase
  endfunction

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 stall after reset", {31'b0, stall}, 0);
    chk("R1 err after reset", {31'b0, mgmt_err}, 0);
    chk("R6 sel idle", {30'b0, sel}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mgmt_valid  = VEC[i][15];
      mgmt_op     = VEC[i][14];
      mgmt_slot   = VEC[i][13:10];
      mgmt_id     = idv(int'(VEC[i][9:8]));
      issue_valid = VEC[i][7];
      issue_slot  = VEC[i][6:4];
      #1;
      chk($sformatf("R%0d vec%0d sel", VEC[i][19:16], i), {30'b0, sel}, {30'b0, VEC[i][3:2]});
      chk($sformatf("R%0d vec%0d trap", VEC[i][19:16], i), {31'b0, trap}, {31'b0, VEC[i][1]});
      chk($sformatf("R%0d vec%0d stall", VEC[i][19:16], i), {31'b0, stall}, {31'b0, VEC[i][0]});
    end

    // R9 error flag pulse timing
    @(negedge clk); idle(); mgmt_valid = 1; mgmt_op = 1; mgmt_slot = 4'd15; mgmt_id = ID0;
    #1 chk("R9 err not yet", {31'b0, mgmt_err}, 0);
    @(negedge clk); idle(); issue_valid = 1; issue_slot = 3'd7;
    #1 chk("R9 err pulse", {31'b0, mgmt_err}, 1);
    chk("R9 slot7 kept", {30'b0, sel}, 2);
    @(negedge clk); idle(); mgmt_valid = 1; mgmt_op = 0; mgmt_slot = 4'd7;
    #1 chk("R8 close stalls", {31'b0, stall}, 1);
    @(negedge clk); idle();
    #1 chk("R9 err one cycle", {31'b0, mgmt_err}, 0);

    // R1 reset clears bindings
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; issue_valid = 1; issue_slot = 3'd3;
    #1 chk("R1 slot3 cleared", {31'b0, trap}, 1);
    chk("R1 slot3 sel", {30'b0, sel}, 0);
    @(negedge clk); idle();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule